// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage in-order pipeline resolves its data and structural hazards. It compares the destination fields of the instructions sitting in Execute and Memory against the two source fields of the instruction in Decode. From that comparison it produces a bypass choice for each ALU operand. It detects a load whose result is needed by the very next instruction and requests a one-cycle bubble. It also manages a multi-cycle multiply/divide unit: it strobes that unit's operand latch when an operation begins and keeps the front end frozen until the unit reports completion.

All freeze causes combine into one stall output. That stall holds the program counter and the Fetch/Decode register. While the stall is high, both bypass choices are forced to the register-file path, so no stale bypass value is captured downstream. A branch flush that arrives while a multiply/divide is running is held back and released in the cycle after the stall lifts. Instructions already in flight are therefore never discarded.

The sequencing lives in a small state machine with five states:
- `ST_RUN`: normal flow.
- `ST_LU_BUBBLE`: the single cycle after a load-use stall. The load-use detector is masked here.
- `ST_MD_WAIT`: a multiply/divide is running.
- `ST_MD_WAIT_FL`: a multiply/divide is running and a flush is pending.
- `ST_FLUSH_REPLAY`: the deferred flush is issued.

The transitions are:
- `ST_RUN`/`ST_LU_BUBBLE` → `ST_MD_WAIT` on a start.
- `ST_RUN`/`ST_LU_BUBBLE` → `ST_MD_WAIT_FL` on a start that coincides with a flush request.
- `ST_RUN` → `ST_LU_BUBBLE` on a load-use hit.
- `ST_LU_BUBBLE` → `ST_RUN` otherwise.
- `ST_MD_WAIT` → `ST_MD_WAIT_FL` on a flush request.
- `ST_MD_WAIT` → `ST_RUN` on done.
- `ST_MD_WAIT` → `ST_FLUSH_REPLAY` on done with a flush request.
- `ST_MD_WAIT_FL` → `ST_FLUSH_REPLAY` on done.
- `ST_FLUSH_REPLAY` → `ST_RUN` always.

Top module: `hazard_ctrl`

## Requirements
- R1: When Execute writes a nonzero register equal to an operand's source and no stall is active, that operand's select is 2'b10 (Execute bypass) in the same cycle.
- R2: When only Memory writes a nonzero register equal to an operand's source, that select is 2'b01 (Memory bypass). With no match the select is 2'b00 (register file). The value 2'b11 never appears.
- R3: When Execute and Memory both match the same source, Execute wins (2'b10).
- R4: A destination of register 0 never produces a bypass select and never raises a load-use stall.
- R5: A load in Execute (memread and regwrite set) whose nonzero destination equals a used source of the Decode instruction raises stall and ex_bubble in that same cycle. They stay high for exactly one cycle, even if the inputs stay unchanged in the next cycle.
- R6: A multiply/divide start in normal flow raises md_capture for that cycle only. Stall is high from the start cycle through every following cycle until the cycle in which md_done is high; in that cycle stall is low.
- R7: A start request while a multiply/divide is already running produces no md_capture.
- R8: Whenever stall is high, both bypass selects are 2'b00.
- R9: A branch flush request during a running multiply/divide keeps flush low while the unit is busy. Flush is then high for exactly one cycle, the cycle after md_done.
- R10: In normal flow a branch flush request produces flush in the same cycle.
- R11: Stall is the OR of the load-use and multiply/divide conditions. A load-use hit that coincides with a start gives stall, ex_bubble and md_capture together, and stall then stays high until md_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | AW | First source register of the Decode instruction |
| id_rt | input | AW | Second source register of the Decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| ex_rd | input | AW | Destination register of the Execute instruction |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register of the Memory instruction |
| mem_regwrite | input | 1 | Memory instruction writes a register |
| md_start | input | 1 | Multiply/divide operation begins in Execute |
| md_done | input | 1 | Multiply/divide result is ready |
| br_flush_req | input | 1 | Branch resolution requests a flush |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B |
| stall | output | 1 | Freeze program counter and Fetch/Decode register |
| ex_bubble | output | 1 | Clear control bits entering Execute |
| md_capture | output | 1 | Load multiply/divide operand latch |
| flush | output | 1 | Flush younger instructions |

## Verification
The bench instantiates the block with the default register-field width of 5 bits, so register 0 and register 31 are both reachable as match targets. Multiply/divide runs are driven with busy lengths of 17 and 33 cycles, the two ends of the unit's latency range. This brings into reach the stall window edges and a flush request landing in the middle of a long operation. A second start issued inside that window exercises the ignored-request path.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_EX  = 2'b10
    } fwd_sel_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_LU_BUBBLE,
        ST_MD_WAIT,
        ST_MD_WAIT_FL,
        ST_FLUSH_REPLAY
    } hz_state_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          gate,
    output logic [1:0]    sel
);
    logic ex_hit;
    logic mem_hit;

    always_comb begin
        ex_hit  = ex_we  && (ex_rd  != '0) && (ex_rd  == src);
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
    end

    always_comb begin
        sel = FWD_RF;
        if (!gate) begin
            if (ex_hit) begin
                sel = FWD_EX;
            end else if (mem_hit) begin
                sel = FWD_MEM;
            end
        end
    end

endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          id_use_rs,
    input  logic          id_use_rt,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_regwrite,
    input  logic          ex_memread,
    output logic          hit
);
    logic load_live;
    logic rs_dep;
    logic rt_dep;

    always_comb begin
        load_live = ex_memread && ex_regwrite && (ex_rd != '0);
        rs_dep    = id_use_rs && (id_rs == ex_rd);
        rt_dep    = id_use_rt && (id_rt == ex_rd);
        hit       = load_live && (rs_dep || rt_dep);
    end

endmodule

// File: rtl/hz_md_fsm.sv
module hz_md_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lu_hit,
    input  logic md_start,
    input  logic md_done,
    input  logic br_flush_req,
    output logic stall,
    output logic ex_bubble,
    output logic md_capture,
    output logic flush
);
    hz_state_e state_q;
    hz_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (md_start) begin
                    state_d = br_flush_req ? ST_MD_WAIT_FL : ST_MD_WAIT;
                end else if (lu_hit) begin
                    state_d = ST_LU_BUBBLE;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_LU_BUBBLE: begin
                if (md_start) begin
                    state_d = br_flush_req ? ST_MD_WAIT_FL : ST_MD_WAIT;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_MD_WAIT: begin
                if (md_done) begin
                    state_d = br_flush_req ? ST_FLUSH_REPLAY : ST_RUN;
                end else if (br_flush_req) begin
                    state_d = ST_MD_WAIT_FL;
                end else begin
                    state_d = ST_MD_WAIT;
                end
            end
            ST_MD_WAIT_FL: begin
                state_d = md_done ? ST_FLUSH_REPLAY : ST_MD_WAIT_FL;
            end
            ST_FLUSH_REPLAY: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        stall      = 1'b0;
        ex_bubble  = 1'b0;
        md_capture = 1'b0;
        flush      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall      = lu_hit || md_start;
                ex_bubble  = lu_hit;
                md_capture = md_start;
                flush      = br_flush_req && !md_start;
            end
            ST_LU_BUBBLE: begin
                stall      = md_start;
                md_capture = md_start;
                flush      = br_flush_req && !md_start;
            end
            ST_MD_WAIT, ST_MD_WAIT_FL: begin
                stall = !md_done;
            end
            ST_FLUSH_REPLAY: begin
                flush = 1'b1;
            end
            default: begin
                stall = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          id_use_rs,
    input  logic          id_use_rt,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_regwrite,
    input  logic          ex_memread,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_regwrite,
    input  logic          md_start,
    input  logic          md_done,
    input  logic          br_flush_req,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          stall,
    output logic          ex_bubble,
    output logic          md_capture,
    output logic          flush
);
    logic          lu_hit;
    logic          stall_w;
    logic [AW-1:0] src_vec [NUM_OPERANDS];
    logic [1:0]    sel_vec [NUM_OPERANDS];

    assign src_vec[0] = id_rs;
    assign src_vec[1] = id_rt;

    hz_loaduse #(.AW(AW)) u_loaduse (
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .id_use_rs   (id_use_rs),
        .id_use_rt   (id_use_rt),
        .ex_rd       (ex_rd),
        .ex_regwrite (ex_regwrite),
        .ex_memread  (ex_memread),
        .hit         (lu_hit)
    );

    hz_md_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .lu_hit       (lu_hit),
        .md_start     (md_start),
        .md_done      (md_done),
        .br_flush_req (br_flush_req),
        .stall        (stall_w),
        .ex_bubble    (ex_bubble),
        .md_capture   (md_capture),
        .flush        (flush)
    );

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_fwd
        hz_fwd_pick #(.AW(AW)) u_pick (
            .src    (src_vec[g]),
            .ex_rd  (ex_rd),
            .ex_we  (ex_regwrite),
            .mem_rd (mem_rd),
            .mem_we (mem_regwrite),
            .gate   (stall_w),
            .sel    (sel_vec[g])
        );
    end

    assign fwd_a_sel = sel_vec[0];
    assign fwd_b_sel = sel_vec[1];
    assign stall     = stall_w;

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs,
    input logic [AW-1:0] id_rt,
    input logic [AW-1:0] ex_rd,
    input logic          ex_regwrite,
    input logic          ex_memread,
    input logic          md_start,
    input logic          md_done,
    input logic          br_flush_req,
    input logic [1:0]    fwd_a_sel,
    input logic [1:0]    fwd_b_sel,
    input logic          stall,
    input logic          ex_bubble,
    input logic          md_capture,
    input logic          flush
);
    assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

    assert_zero_src_rf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0) |-> (fwd_a_sel == 2'b00));

    assert_zero_load_no_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_memread && ex_rd == '0) |-> !ex_bubble);

    assert_bubble_with_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> stall);

    assert_bubble_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> !ex_bubble);

    assert_capture_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        md_capture |-> stall);

    assert_capture_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        md_capture |=> !md_capture);

    assert_stall_gates_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

    assert_busy_no_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !ex_bubble && !md_capture) |-> !flush);

endmodule

bind hazard_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .ex_rd        (ex_rd),
    .ex_regwrite  (ex_regwrite),
    .ex_memread   (ex_memread),
    .md_start     (md_start),
    .md_done      (md_done),
    .br_flush_req (br_flush_req),
    .fwd_a_sel    (fwd_a_sel),
    .fwd_b_sel    (fwd_b_sel),
    .stall        (stall),
    .ex_bubble    (ex_bubble),
    .md_capture   (md_capture),
    .flush        (flush)
);

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs, id_rt, ex_rd, mem_rd;
    logic          id_use_rs, id_use_rt, ex_regwrite, ex_memread, mem_regwrite;
    logic          md_start, md_done, br_flush_req;
    logic [1:0]    fwd_a_sel, fwd_b_sel;
    logic          stall, ex_bubble, md_capture, flush;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hazard_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .ex_rd(ex_rd), .ex_regwrite(ex_regwrite), .ex_memread(ex_memread),
        .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
        .md_start(md_start), .md_done(md_done), .br_flush_req(br_flush_req),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall(stall),
        .ex_bubble(ex_bubble), .md_capture(md_capture), .flush(flush)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        id_rs = '0; id_rt = '0; id_use_rs = 1'b0; id_use_rt = 1'b0;
        ex_rd = '0; ex_regwrite = 1'b0; ex_memread = 1'b0;
        mem_rd = '0; mem_regwrite = 1'b0;
        md_start = 1'b0; md_done = 1'b0; br_flush_req = 1'b0;
    endtask

    // drive at the falling edge, sample 1 ns later
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step(); #1;
        check("R6 reset stall", stall, 0);
        check("R10 reset flush", flush, 0);
        check("R6 reset capture", md_capture, 0);
        check("R2 reset sel a", fwd_a_sel, 0);
    endtask

    task automatic t_forward();
        step(); clear_inputs();
        id_rs = 5'd3; id_rt = 5'd4; id_use_rs = 1; id_use_rt = 1;
        ex_rd = 5'd3; ex_regwrite = 1; mem_rd = 5'd4; mem_regwrite = 1; #1;
        check("R1 ex bypass a", fwd_a_sel, 2);
        check("R2 mem bypass b", fwd_b_sel, 1);
        step(); id_rs = 5'd31; id_rt = 5'd31; ex_rd = 5'd31; mem_rd = 5'd31; #1;
        check("R3 both match a", fwd_a_sel, 2);
        check("R3 both match b", fwd_b_sel, 2);
        step(); id_rs = 5'd9; id_rt = 5'd10; ex_rd = 5'd1; mem_rd = 5'd2; #1;
        check("R2 no match a", fwd_a_sel, 0);
        check("R2 no match b", fwd_b_sel, 0);
        step(); id_rs = 5'd0; id_rt = 5'd0; ex_rd = 5'd0; mem_rd = 5'd0;
        ex_memread = 1; #1;
        check("R4 zero sel a", fwd_a_sel, 0);
        check("R4 zero sel b", fwd_b_sel, 0);
        check("R4 zero no stall", stall, 0);
        step(); clear_inputs(); #1;
    endtask

    task automatic t_loaduse();
        step(); clear_inputs();
        id_rs = 5'd7; id_rt = 5'd7; id_use_rs = 1; id_use_rt = 1;
        ex_rd = 5'd7; ex_regwrite = 1; ex_memread = 1; #1;
        check("R5 lu stall", stall, 1);
        check("R5 lu bubble", ex_bubble, 1);
        check("R8 gated sel a", fwd_a_sel, 0);
        check("R8 gated sel b", fwd_b_sel, 0);
        step(); #1;  // inputs unchanged
        check("R5 one cycle stall", stall, 0);
        check("R5 one cycle bubble", ex_bubble, 0);
        check("R1 bypass after stall", fwd_a_sel, 2);
        step(); clear_inputs();
        id_rt = 5'd7; id_use_rt = 0; ex_rd = 5'd7; ex_regwrite = 1; ex_memread = 1; #1;
        check("R5 unused source no stall", stall, 0);
        step(); clear_inputs(); #1;
    endtask

    task automatic t_muldiv(input int lat, input int flush_at, input bit with_lu);
        step(); clear_inputs();
        md_start = 1;
        if (with_lu) begin
            id_rs = 5'd6; id_use_rs = 1; ex_rd = 5'd6; ex_regwrite = 1; ex_memread = 1;
        end
        #1;
        check("R6 capture at start", md_capture, 1);
        check("R6 stall at start", stall, 1);
        if (with_lu) check("R11 bubble with start", ex_bubble, 1);
        for (int c = 2; c < lat; c++) begin
            step(); md_start = 0; br_flush_req = (c == flush_at);
            if (c == 4) md_start = 1;
            #1;
            check("R6 busy stall", stall, 1);
            check("R7 no capture while busy", md_capture, 0);
            check("R9 no flush while busy", flush, 0);
            if (with_lu) check("R11 no bubble while busy", ex_bubble, 0);
        end
        step(); clear_inputs(); md_done = 1; #1;
        check("R6 stall released on done", stall, 0);
        check("R9 no flush on done", flush, 0);
        step(); clear_inputs(); #1;
        check("R9 deferred flush", flush, (flush_at > 0) ? 1 : 0);
        check("R6 idle after done", stall, 0);
        step(); #1;
        check("R9 flush single cycle", flush, 0);
    endtask

    task automatic t_flush_run();
        step(); clear_inputs(); br_flush_req = 1; #1;
        check("R10 immediate flush", flush, 1);
        check("R10 no stall", stall, 0);
        step(); clear_inputs(); #1;
        check("R10 flush drop", flush, 0);
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_forward();
        t_loaduse();
        t_muldiv(17, 0, 1'b0);
        t_muldiv(33, 10, 1'b0);
        t_muldiv(17, 0, 1'b1);
        t_flush_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule